// File: doc/BRIEF.md
# Parallel Configuration Byte Streamer

This controller brings a downstream programmable device up from power-on. After reset it pulls a shared open-drain handshake line low for a selectable hold-off, then lets go of it. It waits until the line actually reads high, because any other agent may keep the line low to lengthen the reset. It then reads a bitstream one byte at a time from a synchronous read port and presents each byte on an 8-bit bus. A configuration clock, divided down from the system clock, goes with the bus. A byte changes only when that clock falls, so the target samples a settled byte on each rising edge.

Once the last byte is out, the controller watches a done-feedback chip-select input. If the input goes low, the load is complete. If it stays high past a timeout, the controller reports an error, holds the handshake line low for one more hold-off period and streams again from the first byte. When the target restarts on its own, it pulls both the chip select and the handshake line low. The controller treats this as an abort and returns to waiting for the line. A separate open-drain request output can be pulsed low to make the target start a new configuration.

Each open-drain pin is modelled as a drive-low enable. The level seen on the shared line is a separate input.

Top module: `cfg_stream_ctrl`

## Requirements
- R1: `data_o` changes only in the cycle `dclk_o` falls, or when streaming starts with `dclk_o` low. It is constant while `dclk_o` is high. The rising edges of `dclk_o` present bytes from addresses 0, 1, 2 and so on, in that order.
- R2: Reset gives status 0 (idle) with the handshake drive asserted. Idle lasts one cycle, then the hold state begins. `hs_drive_low_o` is 1 exactly in the idle, hold and error states.
- R3: The hold state lasts HOLD_SHORT cycles when `hold_sel`=0 and HOLD_LONG cycles when `hold_sel`=1.
- R4: In the wait state the controller never starts streaming while `hs_line_i` reads 0, so an outside agent can stretch the reset for as long as it likes. Streaming starts on the first edge, from the second wait cycle onward, at which the line reads 1.
- R5: Streaming begins with `dclk_o` low and `mem_addr_o`=1. `dclk_o` toggles every CLK_DIV cycles. After NUM_BYTES rising edges, the next falling point moves to the check state with `dclk_o` low.
- R6: In the stream, check or done state, `hs_line_i`=0 together with `done_cs_i`=0 causes an abort. At the next edge the state is wait, `dclk_o` is 0 and the address is 0, so the next stream restarts at byte 0.
- R7: In the check state, `done_cs_i`=0 with the line high moves to the done state at the next edge. The controller stays in done until an abort.
- R8: If `done_cs_i` stays 1 for DONE_WAIT check cycles, the state becomes error. The error state drives the handshake line low for one hold-off period, holds the address at 0, then returns to wait.
- R9: A one-cycle `reconf_req_i` makes `reconf_drive_low_o` 1 for REQ_CYC cycles, starting the next cycle. A new request restarts that count.
- R10: `status_o` encodes the state: 0 idle, 1 hold, 2 wait, 3 stream, 4 check, 5 done, 6 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_sel | input | 1 | Hold-off length select: 0 short, 1 long |
| hs_line_i | input | 1 | Level read back from the shared handshake line |
| hs_drive_low_o | output | 1 | Pulls the handshake line low when 1 |
| done_cs_i | input | 1 | Done feedback from the target; low means loaded |
| reconf_req_i | input | 1 | Command to request a new configuration |
| reconf_drive_low_o | output | 1 | Pulls the open-drain request line low when 1 |
| mem_addr_o | output | ADDR_W | Bitstream read address |
| mem_data_i | input | DATA_W | Read data, valid one cycle after the address |
| dclk_o | output | 1 | Generated configuration clock |
| data_o | output | DATA_W | Configuration byte bus |
| status_o | output | 3 | State code |

## Verification
Every state decision shows on `status_o`, `hs_drive_low_o` and `dclk_o` one edge after the inputs that cause it, and `reconf_drive_low_o` rises one edge after a request. The bench therefore drives its inputs on the falling clock edge. A behavioural model steps at the rising edge, and the outputs are compared with that model at the following falling edge. Inside a stream, the model counts elapsed cycles: the byte due is the count divided by twice CLK_DIV, and the clock level is the count divided by CLK_DIV, taken modulo two. Separate monitors latch a byte on each rising `dclk_o`, measure how long the hold state lasts and how long the request pulse lasts, and check each of these against the figures in the requirements.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HOLD   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_STREAM = 3'd3,
    ST_CHECK  = 3'd4,
    ST_DONE   = 3'd5,
    ST_ERR    = 3'd6
  } cfgs_state_e;

  // Length of one hold-off period in system cycles.
  function automatic int unsigned hold_cycles(logic sel, int unsigned short_c,
                                              int unsigned long_c);
    return sel ? long_c : short_c;
  endfunction

  // System cycles spent in the stream state for a whole bitstream.
  function automatic int unsigned stream_cycles(int unsigned div, int unsigned nbytes);
    return 2 * div * nbytes;
  endfunction

  // Largest value any shared counter must reach.
  function automatic int unsigned cnt_top(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/cfgs_fsm.sv
module cfgs_fsm
  import cfgs_pkg::*;
#(
  parameter int unsigned HOLD_SHORT = 24,
  parameter int unsigned HOLD_LONG  = 90,
  parameter int unsigned CLK_DIV    = 2,
  parameter int unsigned DONE_WAIT  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hold_sel,
  input  logic        hs_line_i,
  input  logic        done_cs_i,
  input  logic        dclk_q,
  input  logic        last_byte,
  output cfgs_state_e state,
  output logic        start_ev,
  output logic        rise_ev,
  output logic        next_ev,
  output logic        end_ev,
  output logic        clr_ev,
  output logic        abort_ev
);
  localparam int unsigned TOP_CNT = cnt_top(HOLD_SHORT, HOLD_LONG, CLK_DIV, DONE_WAIT);
  localparam int CNT_W = $clog2(TOP_CNT + 1);

  cfgs_state_e      st_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic [CNT_W-1:0] hold_lim, div_lim, wait_lim;
  logic             in_tx, div_wrap, hold_end, ok_ev, tmo_ev;

  assign hold_lim = CNT_W'(hold_cycles(hold_sel, HOLD_SHORT, HOLD_LONG) - 1);
  assign div_lim  = CNT_W'(CLK_DIV - 1);
  assign wait_lim = CNT_W'(DONE_WAIT - 1);

  assign in_tx    = (state == ST_STREAM) || (state == ST_CHECK) || (state == ST_DONE);
  assign abort_ev = in_tx && !hs_line_i && !done_cs_i;
  assign div_wrap = (state == ST_STREAM) && (cnt == div_lim) && !abort_ev;
  assign hold_end = ((state == ST_HOLD) || (state == ST_ERR)) && (cnt == hold_lim);
  assign start_ev = (state == ST_WAIT) && hs_line_i && (cnt != '0);
  assign rise_ev  = div_wrap && !dclk_q;
  assign next_ev  = div_wrap && dclk_q && !last_byte;
  assign end_ev   = div_wrap && dclk_q && last_byte;
  assign clr_ev   = abort_ev || (state == ST_HOLD) || (state == ST_ERR);
  assign ok_ev    = (state == ST_CHECK) && !abort_ev && !done_cs_i;
  assign tmo_ev   = (state == ST_CHECK) && !abort_ev && done_cs_i && (cnt == wait_lim);

  always_comb begin
    st_d  = state;
    cnt_d = cnt + 1'b1;
    case (state)
      ST_IDLE: begin
        st_d  = ST_HOLD;
        cnt_d = '0;
      end
      ST_HOLD, ST_ERR: begin
        if (hold_end) begin
          st_d  = ST_WAIT;
          cnt_d = '0;
        end
      end
      ST_WAIT: begin
        cnt_d = CNT_W'(1);
        if (start_ev) begin
          st_d  = ST_STREAM;
          cnt_d = '0;
        end
      end
      ST_STREAM: begin
        if (abort_ev) begin
          st_d  = ST_WAIT;
          cnt_d = '0;
        end else if (div_wrap) begin
          cnt_d = '0;
          if (end_ev) st_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (abort_ev) begin
          st_d  = ST_WAIT;
          cnt_d = '0;
        end else if (ok_ev) begin
          st_d  = ST_DONE;
          cnt_d = '0;
        end else if (tmo_ev) begin
          st_d  = ST_ERR;
          cnt_d = '0;
        end
      end
      ST_DONE: begin
        cnt_d = '0;
        if (abort_ev) st_d = ST_WAIT;
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= st_d;
      cnt   <= cnt_d;
    end
  end

endmodule

// File: rtl/cfgs_byte_path.sv
module cfgs_byte_path #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_BYTES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_ev,
  input  logic              start_ev,
  input  logic              rise_ev,
  input  logic              next_ev,
  input  logic              end_ev,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              dclk_q,
  output logic              last_byte
);
  localparam int SENT_W = $clog2(NUM_BYTES + 1);

  logic [SENT_W-1:0] sent_q;

  assign last_byte = (sent_q == SENT_W'(NUM_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      dclk_q <= 1'b0;
      sent_q <= '0;
    end else if (clr_ev) begin
      addr_q <= '0;
      dclk_q <= 1'b0;
    end else if (start_ev) begin
      data_q <= mem_data_i;
      addr_q <= ADDR_W'(1);
      sent_q <= SENT_W'(1);
      dclk_q <= 1'b0;
    end else if (rise_ev) begin
      dclk_q <= 1'b1;
    end else if (next_ev) begin
      data_q <= mem_data_i;
      addr_q <= addr_q + 1'b1;
      sent_q <= sent_q + 1'b1;
      dclk_q <= 1'b0;
    end else if (end_ev) begin
      dclk_q <= 1'b0;
    end
  end

endmodule

// File: rtl/cfgs_req_pulse.sv
module cfgs_req_pulse #(
  parameter int unsigned REQ_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic drive_low_o
);
  localparam int REQ_W = $clog2(REQ_CYC + 1);

  logic [REQ_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (req_i)          left_q <= REQ_W'(REQ_CYC);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign drive_low_o = (left_q != '0);

endmodule

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl
  import cfgs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NUM_BYTES  = 12,
  parameter int unsigned CLK_DIV    = 2,
  parameter int unsigned HOLD_SHORT = 24,
  parameter int unsigned HOLD_LONG  = 90,
  parameter int unsigned DONE_WAIT  = 10,
  parameter int unsigned REQ_CYC    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_sel,
  input  logic              hs_line_i,
  output logic              hs_drive_low_o,
  input  logic              done_cs_i,
  input  logic              reconf_req_i,
  output logic              reconf_drive_low_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              dclk_o,
  output logic [DATA_W-1:0] data_o,
  output logic [2:0]        status_o
);
  cfgs_state_e state;
  logic start_ev, rise_ev, next_ev, end_ev, clr_ev, abort_ev;
  logic dclk_q, last_byte;

  cfgs_fsm #(
    .HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG),
    .CLK_DIV(CLK_DIV), .DONE_WAIT(DONE_WAIT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .hold_sel(hold_sel), .hs_line_i(hs_line_i),
    .done_cs_i(done_cs_i), .dclk_q(dclk_q), .last_byte(last_byte),
    .state(state), .start_ev(start_ev), .rise_ev(rise_ev), .next_ev(next_ev),
    .end_ev(end_ev), .clr_ev(clr_ev), .abort_ev(abort_ev)
  );

  cfgs_byte_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES)
  ) u_bytes (
    .clk(clk), .rst_n(rst_n), .clr_ev(clr_ev), .start_ev(start_ev),
    .rise_ev(rise_ev), .next_ev(next_ev), .end_ev(end_ev),
    .mem_data_i(mem_data_i), .addr_q(mem_addr_o), .data_q(data_o),
    .dclk_q(dclk_q), .last_byte(last_byte)
  );

  cfgs_req_pulse #(.REQ_CYC(REQ_CYC)) u_req (
    .clk(clk), .rst_n(rst_n), .req_i(reconf_req_i), .drive_low_o(reconf_drive_low_o)
  );

  assign hs_drive_low_o = (state == ST_IDLE) || (state == ST_HOLD) || (state == ST_ERR);
  assign dclk_o         = dclk_q;
  assign status_o       = state;

endmodule

// File: rtl/cfgs_chk.sv
module cfgs_chk
  import cfgs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned HOLD_SHORT = 24,
  parameter int unsigned HOLD_LONG  = 90
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_sel,
  input logic              hs_line_i,
  input logic              done_cs_i,
  input logic              reconf_req_i,
  input logic              reconf_drive_low_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              dclk_o,
  input logic [DATA_W-1:0] data_o,
  input logic [2:0]        status_o,
  input logic              abort_ev
);
  int unsigned hold_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hold_run <= 0;
    else if (status_o == ST_HOLD) hold_run <= hold_run + 1;
    else                         hold_run <= 0;
  end

  // R1
  byte_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_o && $past(dclk_o)) |-> $stable(data_o));

  // R3
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == ST_WAIT && $past(status_o) == ST_HOLD) |->
      (hold_run == hold_cycles($past(hold_sel), HOLD_SHORT, HOLD_LONG)));

  // R4
  line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == ST_WAIT && !hs_line_i) |=> (status_o != ST_STREAM));

  // R5
  stream_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == ST_STREAM && $past(status_o) == ST_WAIT) |->
      (!dclk_o && mem_addr_o == ADDR_W'(1)));

  // R6
  abort_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (status_o == ST_WAIT && !dclk_o && mem_addr_o == '0));

  // R7
  done_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == ST_CHECK && !done_cs_i && hs_line_i) |=> (status_o == ST_DONE));

  // R8
  err_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == ST_ERR && $past(status_o) == ST_ERR) |-> (mem_addr_o == '0));

  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_req_i |=> reconf_drive_low_o);

endmodule

bind cfg_stream_ctrl cfgs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_sel(hold_sel), .hs_line_i(hs_line_i),
  .done_cs_i(done_cs_i), .reconf_req_i(reconf_req_i),
  .reconf_drive_low_o(reconf_drive_low_o), .mem_addr_o(mem_addr_o),
  .dclk_o(dclk_o), .data_o(data_o), .status_o(status_o), .abort_ev(abort_ev)
);

// File: tb/cfg_stream_ctrl_tb_top.sv
module cfg_stream_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NB = 12;
  localparam int DV = 2;
  localparam int HS = 24;
  localparam int HL = 90;
  localparam int DW8 = 10;
  localparam int RQ = 5;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n, hold_sel, done_cs, req, ext_low, tgt_low;
  logic hs_drive, reconf_drive, dclk;
  logic [AW-1:0] addr;
  logic [DW-1:0] mem_q, data;
  logic [2:0] status;
  wire hs_line = !(hs_drive || ext_low || tgt_low);

  int total = 0, bad = 0, cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] rom(int a);
    return 8'((a * 37 + 5) % 256);
  endfunction

  always @(posedge clk) mem_q <= rom(int'(addr));

  cfg_stream_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .NUM_BYTES(NB), .CLK_DIV(DV), .HOLD_SHORT(HS),
    .HOLD_LONG(HL), .DONE_WAIT(DW8), .REQ_CYC(RQ)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .hold_sel(hold_sel), .hs_line_i(hs_line),
    .hs_drive_low_o(hs_drive), .done_cs_i(done_cs), .reconf_req_i(req),
    .reconf_drive_low_o(reconf_drive), .mem_addr_o(addr), .mem_data_i(mem_q),
    .dclk_o(dclk), .data_o(data), .status_o(status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference, stepped on the rising edge.
  int ms = 0, mt = 0, rc = 0;
  bit started = 0;
  always @(posedge clk) begin
    int hold;
    bit line, abort;
    started = 1;
    if (!rst_n) begin
      ms = 0; mt = 0; rc = 0;
    end else begin
      line  = !((ms == 0 || ms == 1 || ms == 6) || ext_low || tgt_low);
      hold  = hold_sel ? HL : HS;
      abort = (ms >= 3 && ms <= 5) && !line && !done_cs;
      if (req) rc = RQ; else if (rc > 0) rc--;
      case (ms)
        0: begin ms = 1; mt = 0; end
        1, 6: if (mt == hold - 1) begin ms = 2; mt = 0; end else mt++;
        2: if (mt >= 1 && line) begin ms = 3; mt = 0; end else mt++;
        3: if (abort) begin ms = 2; mt = 0; end
           else if (mt == 2 * DV * NB - 1) begin ms = 4; mt = 0; end
           else mt++;
        4: if (abort) begin ms = 2; mt = 0; end
           else if (!done_cs) begin ms = 5; mt = 0; end
           else if (mt == DW8 - 1) begin ms = 6; mt = 0; end
           else mt++;
        5: if (abort) begin ms = 2; mt = 0; end
        default: ms = 0;
      endcase
    end
  end

  function automatic string tag_of(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R7";
      5: return "R7";
      6: return "R8";
      default: return "R10";
    endcase
  endfunction

  // Per-clock comparison and monitors at the falling edge.
  int cap_cnt = 0, hold_seen = 0, prev_status = 0;
  bit prev_dclk = 0;
  logic [DW-1:0] prev_data = '0;
  always @(negedge clk) begin
    if (started) begin
      chk(int'(status) == ms, {tag_of(ms), " R10 status"}, int'(status), ms);
      chk(hs_drive == (ms == 0 || ms == 1 || ms == 6), "R2 handshake drive",
          int'(hs_drive), int'(ms == 0 || ms == 1 || ms == 6));
      chk(dclk == (ms == 3 && ((mt / DV) % 2 == 1)), "R5 dclk level",
          int'(dclk), int'(ms == 3 && ((mt / DV) % 2 == 1)));
      chk(reconf_drive == (rc > 0), "R9 request drive", int'(reconf_drive), int'(rc > 0));
      if (ms == 3)
        chk(data == rom(mt / (2 * DV)), "R1 stream byte", int'(data), int'(rom(mt / (2 * DV))));
      else if (ms == 4 || ms == 5)
        chk(data == rom(NB - 1), "R5 last byte held", int'(data), int'(rom(NB - 1)));
    end
    if (status == 3'd3 && prev_status != 3 && dclk == 1'b0) cap_cnt = 0;
    if (dclk && !prev_dclk) begin
      chk(data == rom(cap_cnt), "R1 byte at rising dclk", int'(data), int'(rom(cap_cnt)));
      cap_cnt++;
    end
    if (dclk && prev_dclk)
      chk(data == prev_data, "R1 byte steady while high", int'(data), int'(prev_data));
    if (status == 3'd0) hold_seen = 0;
    else if (status == 3'd1) hold_seen++;
    prev_dclk = dclk;
    prev_data = data;
    prev_status = int'(status);
  end

  task automatic wait_st(input int s);
    while (int'(status) != s) @(negedge clk);
  endtask

  task automatic do_reset(input logic sel);
    rst_n = 1'b0; hold_sel = sel; ext_low = 1'b0; tgt_low = 1'b0;
    done_cs = 1'b1; req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi;
    do_reset(1'b0);
    // R2 R10: reset state
    chk(status == 3'd0, "R10 reset status", int'(status), 0);
    chk(hs_drive == 1'b1, "R2 reset drive", int'(hs_drive), 1);
    chk(dclk == 1'b0 && data == '0, "R2 reset bus", int'(data), 0);
    rst_n = 1'b1;
    ext_low = 1'b1;
    wait_st(2);
    // R3: short hold-off
    chk(hold_seen == HS, "R3 short hold length", hold_seen, HS);
    // R4: external stretch keeps the controller waiting
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk(status == 3'd2, "R4 stretched wait", int'(status), 2);
    end
    ext_low = 1'b0;
    wait_st(3);
    wait_st(4);
    chk(cap_cnt == NB, "R5 bytes sent", cap_cnt, NB);
    repeat (3) @(negedge clk);
    done_cs = 1'b0;
    repeat (2) @(negedge clk);
    chk(status == 3'd5, "R7 done reached", int'(status), 5);
    // R6: target restart while done
    tgt_low = 1'b1;
    @(negedge clk);
    chk(status == 3'd2, "R6 abort from done", int'(status), 2);
    tgt_low = 1'b0; done_cs = 1'b1;
    wait_st(3);
    wait_st(4);
    wait_st(6);
    // R8: timeout leads to error with line held low
    chk(hs_drive == 1'b1, "R8 error drives line", int'(hs_drive), 1);
    wait_st(2);
    wait_st(3);
    repeat (9) @(negedge clk);
    // R6: abort mid-stream
    tgt_low = 1'b1; done_cs = 1'b0;
    @(negedge clk);
    chk(status == 3'd2 && dclk == 1'b0, "R6 abort from stream", int'(status), 2);
    chk(addr == '0, "R6 address cleared", int'(addr), 0);
    tgt_low = 1'b0; done_cs = 1'b1;
    wait_st(3);
    wait_st(4);
    chk(cap_cnt == NB, "R6 full restream", cap_cnt, NB);
    done_cs = 1'b0;
    repeat (2) @(negedge clk);
    chk(status == 3'd5, "R7 done after restream", int'(status), 5);
    // R9: request pulse and retrigger
    req = 1'b1; @(negedge clk); req = 1'b0;
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      if (reconf_drive) hi++;
      @(negedge clk);
    end
    chk(hi == RQ, "R9 pulse length", hi, RQ);
    req = 1'b1; @(negedge clk); req = 1'b0;
    @(negedge clk);
    req = 1'b1; @(negedge clk); req = 1'b0;
    hi = 2;
    for (int i = 0; i < 12; i++) begin
      if (reconf_drive) hi++;
      @(negedge clk);
    end
    chk(hi == RQ + 2, "R9 retrigger length", hi, RQ + 2);
    // R3: long hold-off
    do_reset(1'b1);
    rst_n = 1'b1;
    wait_st(2);
    chk(hold_seen == HL, "R3 long hold length", hold_seen, HL);
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule